// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a multi-function peripheral controller. The host reaches it through a two-byte port. Offset 0 is an index location and offset 1 is a data location. The port is closed after reset. A key byte written to the index location opens it, and a second key byte written there closes it again. While the port is open, the host writes a register number to the index location and then reads or writes that register through the data location.

Behind the port sit three kinds of register. Two are read-only chip identity registers: an identifier and a revision. One is a logical-device number. The last is a bank of 16-bit I/O base addresses, with one high/low pair for each logical device. The pair visible through the data port is the pair of the device the number currently selects. The base address of the hardware-monitor device is also brought out as a port, so that neighbouring decode logic can use it.

The bus is byte-wide and has an address bit, a write strobe and a read strobe. Read data is registered.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is closed, the index register holds 0x00 and the logical-device number is 0.
- R2: A write of 0x55 to offset 0 while closed opens the port. Any other byte written to offset 0 while closed changes neither the open state nor the index register.
- R3: A write of 0xAA to offset 0 while open closes the port. While closed, reads at either offset return 0xFF and writes to offset 1 have no effect on any register.
- R4: While open, a write to offset 0 of any byte other than 0xAA loads that byte into the index register, and a read at offset 0 returns it.
- R5: Register 0x20 reads as the chip identifier (parameter, default 0x6F). Writes to it are discarded.
- R6: Register 0x21 reads as the revision (parameter, default 0x01). Writes to it are discarded.
- R7: Register 0x07 holds the logical-device number. A write stores the low 4 bits of the data byte, and a read returns those 4 bits with the upper nibble zero.
- R8: Register 0x60 holds the high byte and register 0x61 the low byte of the base address of the logical device selected by R7. Each of the 16 devices keeps its own independent pair.
- R9: After reset, every base address is 0x0000 except that of device 8 (the hardware monitor), which is 0x0480 (parameter). Output mon_base always equals device 8's high byte shifted left by 8, OR its low byte.
- R10: While open, a data read at any register number other than 0x07, 0x20, 0x21, 0x60 or 0x61 returns 0x00.
- R11: bus_rdata takes the addressed value on the clock edge at which bus_rd is sampled high. It holds its value on cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Port offset: 0 = index, 1 = data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mon_base | output | 16 | Stored base address of the hardware-monitor device |

## Verification
The assertions check on every cycle the following:
- the key handling: 0x55 opens the port, 0xAA closes it, and other bytes written while closed change nothing;
- the 0xFF value returned by every read while closed;
- the identifier read;
- that the device number and the monitor base address hold when they are not written.

Some behaviour only the bench sweeps can show:
- the read value of every one of the 256 register numbers;
- the independence of the 16 base-address pairs;
- the reset defaults of the bank;
- that writes made while closed leave the stored values unchanged once the port is reopened.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN    = 8'h55;
  localparam logic [7:0] KEY_CLOSE   = 8'hAA;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID      = 8'h20;
  localparam logic [7:0] IDX_REV     = 8'h21;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] CLOSED_READ = 8'hFF;

  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_OPEN   = 1'b1
  } cfg_state_e;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_wr,
  input  logic [DW-1:0] wdata,
  output logic          open_o,
  output logic [DW-1:0] index_o
);
  cfg_state_e    state_q;
  logic [DW-1:0] index_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOCKED;
      index_q <= '0;
    end else if (idx_wr) begin
      case (state_q)
        ST_LOCKED: if (wdata == KEY_OPEN) state_q <= ST_OPEN;
        ST_OPEN: begin
          if (wdata == KEY_CLOSE) state_q <= ST_LOCKED;
          else                    index_q <= wdata;
        end
        default: state_q <= ST_LOCKED;
      endcase
    end
  end

  assign open_o  = (state_q == ST_OPEN);
  assign index_o = index_q;

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_wr && !open_o && wdata == KEY_OPEN) |=> open_o);

  // R2
  key_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_wr && !open_o && wdata != KEY_OPEN) |=> (!open_o && $stable(index_o)));

  // R3
  key_close_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_wr && open_o && wdata == KEY_CLOSE) |=> !open_o);
endmodule

// File: rtl/sio_ldn_bank.sv
module sio_ldn_bank #(
  parameter int          LDN_W    = 4,
  parameter int          DW       = 8,
  parameter int          MON_LDN  = 8,
  parameter logic [15:0] MON_BASE = 16'h0480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LDN_W-1:0] sel,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    sel_hi,
  output logic [DW-1:0]    sel_lo,
  output logic [2*DW-1:0]  mon_base
);
  localparam int DEV_N = 1 << LDN_W;

  logic [DW-1:0] hi_all [DEV_N];
  logic [DW-1:0] lo_all [DEV_N];

  for (genvar g = 0; g < DEV_N; g++) begin : g_dev
    localparam logic [2*DW-1:0] DFLT = (g == MON_LDN) ? MON_BASE : '0;
    logic [DW-1:0] hi_q, lo_q;
    logic          hit;
    assign hit = (sel == LDN_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= DFLT[2*DW-1:DW];
        lo_q <= DFLT[DW-1:0];
      end else begin
        if (wr_hi && hit) hi_q <= wdata;
        if (wr_lo && hit) lo_q <= wdata;
      end
    end
    assign hi_all[g] = hi_q;
    assign lo_all[g] = lo_q;
  end

  assign sel_hi   = hi_all[sel];
  assign sel_lo   = lo_all[sel];
  assign mon_base = {hi_all[MON_LDN], lo_all[MON_LDN]};

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_hi && !wr_lo) |=> $stable(mon_base));
endmodule

// File: rtl/sio_read_mux.sv
module sio_read_mux
  import sio_cfg_pkg::*;
#(
  parameter int         LDN_W    = 4,
  parameter int         DW       = 8,
  parameter logic [7:0] CHIP_ID  = 8'h6F,
  parameter logic [7:0] CHIP_REV = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  logic             addr,
  input  logic             open_i,
  input  logic [DW-1:0]    index,
  input  logic [LDN_W-1:0] ldn,
  input  logic [DW-1:0]    sel_hi,
  input  logic [DW-1:0]    sel_lo,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] val;
  logic [DW-1:0] rdata_q;

  always_comb begin
    if (!open_i)    val = CLOSED_READ;
    else if (!addr) val = index;
    else begin
      case (index)
        IDX_LDN:     val = {{(DW-LDN_W){1'b0}}, ldn};
        IDX_ID:      val = CHIP_ID;
        IDX_REV:     val = CHIP_REV;
        IDX_BASE_HI: val = sel_hi;
        IDX_BASE_LO: val = sel_lo;
        default:     val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= CLOSED_READ;
    else if (rd_stb) rdata_q <= val;
  end

  assign rdata = rdata_q;

  // R3
  closed_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !open_i) |=> (rdata == CLOSED_READ));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rdata));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          LDN_W    = 4,
  parameter int          MON_LDN  = 8,
  parameter logic [15:0] MON_BASE = 16'h0480,
  parameter logic [7:0]  CHIP_ID  = 8'h6F,
  parameter logic [7:0]  CHIP_REV = 8'h01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [15:0] mon_base
);
  localparam int DW = 8;

  logic             open_w;
  logic [DW-1:0]    index_w;
  logic             idx_wr, dat_wr;
  logic [LDN_W-1:0] ldn_q;
  logic [DW-1:0]    sel_hi, sel_lo;

  assign idx_wr = bus_wr && !bus_addr;
  assign dat_wr = bus_wr && bus_addr && open_w;

  sio_key_fsm #(.DW(DW)) u_key (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(bus_wdata),
    .open_o(open_w), .index_o(index_w)
  );

  always_ff @(posedge clk) begin
    if (rst)                               ldn_q <= '0;
    else if (dat_wr && index_w == IDX_LDN) ldn_q <= bus_wdata[LDN_W-1:0];
  end

  sio_ldn_bank #(.LDN_W(LDN_W), .DW(DW), .MON_LDN(MON_LDN), .MON_BASE(MON_BASE)) u_bank (
    .clk(clk), .rst(rst), .sel(ldn_q),
    .wr_hi(dat_wr && index_w == IDX_BASE_HI),
    .wr_lo(dat_wr && index_w == IDX_BASE_LO),
    .wdata(bus_wdata), .sel_hi(sel_hi), .sel_lo(sel_lo), .mon_base(mon_base)
  );

  sio_read_mux #(.LDN_W(LDN_W), .DW(DW), .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_rmux (
    .clk(clk), .rst(rst), .rd_stb(bus_rd), .addr(bus_addr), .open_i(open_w),
    .index(index_w), .ldn(ldn_q), .sel_hi(sel_hi), .sel_lo(sel_lo), .rdata(bus_rdata)
  );

  // R7
  ldn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr) |=> $stable(ldn_q));

  // R5
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr && open_w && index_w == IDX_ID) |=> (bus_rdata == CHIP_ID));
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_addr = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [15:0] mon_base;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mon_base(mon_base)
  );

  logic [7:0] m_hi [16];
  logic [7:0] m_lo [16];
  int         m_ldn;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] expect_reg(input int idx);
    case (idx)
      8'h07:   return 8'(m_ldn);
      8'h20:   return 8'h6F;
      8'h21:   return 8'h01;
      8'h60:   return m_hi[m_ldn];
      8'h61:   return m_lo[m_ldn];
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    logic [7:0] v;
    for (int l = 0; l < 16; l++) begin
      m_hi[l] = (l == 8) ? 8'h04 : 8'h00;
      m_lo[l] = (l == 8) ? 8'h80 : 8'h00;
    end
    m_ldn = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R3: closed after reset
    rd(1'b1, v); chk("R1 closed data read", 16'(v), 16'hFF);
    rd(1'b0, v); chk("R3 closed index read", 16'(v), 16'hFF);
    chk("R9 mon_base reset", mon_base, 16'h0480);

    // R2: open, R1 index and ldn at reset
    wr(1'b0, 8'h55);
    rd(1'b0, v); chk("R1 index reset", 16'(v), 16'h00);
    wr(1'b0, 8'h07);
    rd(1'b1, v); chk("R1 ldn reset", 16'(v), 16'h00);

    // R9: default bank sweep
    for (int l = 0; l < 16; l++) begin
      wr(1'b0, 8'h07); wr(1'b1, 8'(l));
      wr(1'b0, 8'h60); rd(1'b1, v); chk("R9 default hi", 16'(v), 16'(m_hi[l]));
      wr(1'b0, 8'h61); rd(1'b1, v); chk("R9 default lo", 16'(v), 16'(m_lo[l]));
    end

    // R8: write a distinct pair for every device
    for (int l = 0; l < 16; l++) begin
      m_hi[l] = 8'(l * 37 + 5);
      m_lo[l] = 8'(l * 91 + 200);
      wr(1'b0, 8'h07); wr(1'b1, 8'(l) | 8'hF0);
      wr(1'b0, 8'h60); wr(1'b1, m_hi[l]);
      wr(1'b0, 8'h61); wr(1'b1, m_lo[l]);
    end
    // R7: upper nibble dropped
    wr(1'b0, 8'h07); rd(1'b1, v); chk("R7 ldn nibble", 16'(v), 16'h0F);
    m_ldn = 15;
    for (int l = 0; l < 16; l++) begin
      wr(1'b0, 8'h07); wr(1'b1, 8'(l));
      wr(1'b0, 8'h60); rd(1'b1, v); chk("R8 hi readback", 16'(v), 16'(m_hi[l]));
      wr(1'b0, 8'h61); rd(1'b1, v); chk("R8 lo readback", 16'(v), 16'(m_lo[l]));
    end
    m_ldn = 15;
    chk("R9 mon_base tracks device 8", mon_base, {m_hi[8], m_lo[8]});

    // R5 / R6: writes discarded
    wr(1'b0, 8'h20); wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R5 id after write", 16'(v), 16'h6F);
    wr(1'b0, 8'h21); wr(1'b1, 8'hEE);
    rd(1'b1, v); chk("R6 rev after write", 16'(v), 16'h01);

    // R4 / R10 / R5 / R6 / R7 / R8: full register number sweep
    m_ldn = 5;
    wr(1'b0, 8'h07); wr(1'b1, 8'h05);
    for (int i = 0; i < 256; i++) begin
      if (i == 8'hAA) continue;
      wr(1'b0, 8'(i));
      rd(1'b0, v); chk("R4 index readback", 16'(v), 16'(i));
      rd(1'b1, v); chk("R10 register sweep", 16'(v), 16'(expect_reg(i)));
    end

    // R11: read data holds without a read strobe
    wr(1'b0, 8'h20); rd(1'b1, v);
    repeat (4) @(negedge clk);
    chk("R11 rdata held", 16'(bus_rdata), 16'h6F);
    wr(1'b0, 8'h61);

    // R3: close, closed writes ignored
    wr(1'b0, 8'hAA);
    rd(1'b1, v); chk("R3 data read after close", 16'(v), 16'hFF);
    wr(1'b1, 8'h12);
    for (int i = 0; i < 256; i++) begin
      if (i == 8'h55) continue;
      wr(1'b0, 8'(i));
      rd(1'b1, v); chk("R2 stays closed", 16'(v), 16'hFF);
    end
    wr(1'b0, 8'h55);
    rd(1'b0, v); chk("R2 index kept while closed", 16'(v), 16'h61);
    rd(1'b1, v); chk("R3 closed data write ignored", 16'(v), 16'(m_lo[5]));
    chk("R9 mon_base unchanged", mon_base, {m_hi[8], m_lo[8]});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule